// File: doc/BRIEF.md
# Relay-Matrix Shift-Register Sequencer

This block turns short electrode-routing commands into bit-level waveforms for a chain of serial-in, parallel-out latching shift registers. The chain sets each of `NUM_CH` channels (up to 16, default 16) to one of three states: driven as stimulus, driven as reference/ground, or high-impedance. Each channel takes two bits. A host issues a command over a valid/ready handshake. The sequencer then drives serial data, a shift clock, a storage clock and an active-low clear until the new pattern is latched.

Bit-pair codes in the chain are as follows, before polarity is applied: `10` is stimulus, `01` is reference/ground and `00` is high-impedance. Commands use `cmdOp`:

- 0 = all-HiZ
- 1 = all-ground
- 2 = twin (stimulus `cmdChanA`, reference `cmdChanB`)
- 3 = trio (stimulus `cmdChanA`, references `cmdChanB` and `cmdChanC`)
- 4 = one-versus-others (stimulus `cmdChanA`)

Every command that runs takes its polarity from `cmdPol`.

The "chain image" is the pattern the latched outputs hold, seen as a 2N-bit word. On each shift-clock rise, a low clear empties the chain. Otherwise the chain moves one place toward bit 0 and `serData` enters at bit 2N−1. A storage-clock rise copies the chain to the image. Channel c (1-based) of a fully loaded word sits in bits 2c−2 (shifted first) and 2c−1.

Top module: `relay_seq`

## Requirements
- R1: During reset `clearN` is 1 and both clocks are 0. After reset the block runs an all-HiZ sequence on its own, with `cmdReady` low throughout. The image ends at zero, the mode is twin, the polarity is 1 and the stimulus position is 0.
- R2: Each shift or storage pulse is high for exactly `PULSE_W` cycles. Before the next rise the clock stays low for at least `PULSE_W` cycles. `serData` is set at least one cycle before a shift rise and holds while the clock is high. The two clocks are never high together.
- R3: A full load holds `clearN` low across exactly one shift pulse, then shifts 2N bits with `clearN` high, bit 2i before bit 2i+1. The image then equals the encoded state word.
- R4: A pair with exactly one bit set is XORed bitwise with the polarity before shifting. Pairs `00` and `11` are shifted unchanged.
- R5: Every command that runs ends with exactly one storage pulse, and `clearN` is high at its rise.
- R6: All-HiZ gives one cleared shift pulse, then the latch. The image becomes zero and the stimulus position becomes 0.
- R7: All-ground shifts sweep pairs, each pair being (1 XOR pol) then (0 XOR pol), and then latches. If the last completed pattern was already all-ground, the command produces no pulse and leaves the polarity unchanged.
- R8: A sweep is N pairs long. The exception is one-versus-others mode when the state is not all-HiZ: the sweep is then N+1−position pairs.
- R9: The twin word is stimulus code `10` at channel A plus reference code `01` at channel B, added as 2N-bit integers. Trio also adds `01` at channel C. Both record A as the position and select twin mode.
- R10: One-versus-others to channel k has two paths. If the block is in that mode, the position p is nonzero and k ≥ p, it shifts only k−p sweep pairs. Otherwise it does a sweep, then the pair (0 XOR pol, 1 XOR pol), then k−1 sweep pairs. Either way it latches and sets the position to k.
- R11: An opcode of 5 to 7 is accepted and has no effect. So is a command with any needed channel outside 1..N. Neither produces a pulse nor changes the image or later behaviour.
- R12: `cmdReady` is high only when no sequence is in progress. A command held valid while the block is busy is accepted on the first idle cycle and run in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command taken this cycle if valid |
| cmdOp | input | 3 | Command opcode |
| cmdChanA | input | CH_W | Stimulus channel, 1-based |
| cmdChanB | input | CH_W | First reference channel |
| cmdChanC | input | CH_W | Second reference channel (trio) |
| cmdPol | input | 1 | Polarity for this command |
| serData | output | 1 | Serial data to the chain |
| shiftClk | output | 1 | Chain shift clock |
| storeClk | output | 1 | Output storage clock |
| clearN | output | 1 | Active-low chain clear |

## Verification
Two events can land on the same clock edge. One is the end of one command's storage pulse. The other is the acceptance of a following command that has been held valid since the block went busy. The bench provokes this by issuing commands back to back without waiting for idle, including one issued while the reset-time all-HiZ is still running. It judges the result from the cumulative shift and storage pulse counts and from the final image, all of which must match its own command-by-command model. A second coincidence occurs inside a full load: the release of the clear and the launch of the first data bit happen on the same edge. The bench models the chain from the pins alone, so a clear that lingers into the first data shift shows up as a wrong image.

// File: rtl/relay_seq_pkg.sv
package relay_seq_pkg;

  typedef enum logic [2:0] {
    OP_HIZ    = 3'd0,
    OP_GROUND = 3'd1,
    OP_TWIN   = 3'd2,
    OP_TRIO   = 3'd3,
    OP_ONEVS  = 3'd4
  } opCode_e;

  typedef enum logic [1:0] {
    K_HIZ    = 2'd0,
    K_GROUND = 2'd1,
    K_OTHER  = 2'd2
  } chainKind_e;

  // Strobes from sequencing control to the pin datapath
  typedef struct packed {
    logic fireShift;
    logic fireStore;
    logic serBit;
    logic clearLow;
  } strobe_t;

endpackage

// File: rtl/relay_seq_dp.sv
module relay_seq_dp
  import relay_seq_pkg::*;
#(
  parameter int PULSE_W = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    pulseDone,
  output logic    serData,
  output logic    shiftClk,
  output logic    storeClk,
  output logic    clearN
);

  localparam int TW = $clog2(PULSE_W + 1) + 1;

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_HIGH, P_LOW} pulsePh_e;

  pulsePh_e        ph;
  logic [TW-1:0]   tmr;
  logic            isStore;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph        <= P_IDLE;
      tmr       <= '0;
      isStore   <= 1'b0;
      serData   <= 1'b0;
      shiftClk  <= 1'b0;
      storeClk  <= 1'b0;
      clearN    <= 1'b1;
      pulseDone <= 1'b0;
    end else begin
      clearN    <= !strb.clearLow;
      pulseDone <= 1'b0;
      case (ph)
        P_IDLE: begin
          if (strb.fireShift || strb.fireStore) begin
            isStore <= strb.fireStore;
            if (strb.fireShift) serData <= strb.serBit;
            ph <= P_SETUP;
          end
        end
        P_SETUP: begin
          ph  <= P_HIGH;
          tmr <= TW'(PULSE_W - 1);
          if (isStore) storeClk <= 1'b1;
          else         shiftClk <= 1'b1;
        end
        P_HIGH: begin
          if (tmr == '0) begin
            shiftClk <= 1'b0;
            storeClk <= 1'b0;
            ph       <= P_LOW;
            tmr      <= TW'(PULSE_W - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: begin
          if (tmr == '0) begin
            ph        <= P_IDLE;
            pulseDone <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
      endcase
    end
  end

  // R2: the two clocks never overlap
  a_r2_clocks_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftClk && storeClk));

  // R2: data already settled when the shift clock rises
  a_r2_data_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> $stable(serData));

  // R2: data held while the shift clock is high
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> $stable(serData));

endmodule

// File: rtl/relay_seq_ctrl.sv
module relay_seq_ctrl
  import relay_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic [2:0]      cmdOp,
  input  logic [CH_W-1:0] chA,
  input  logic [CH_W-1:0] chB,
  input  logic [CH_W-1:0] chC,
  input  logic            cmdPol,
  input  logic            pulseDone,
  output strobe_t         strb
);

  localparam int WW = 2 * NUM_CH;
  localparam int PW = $clog2(NUM_CH + 2) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_LOAD, S_SWEEP, S_STIM, S_STEP, S_LATCH
  } seqState_e;

  seqState_e       st;
  logic            waiting;
  logic            bitHi;
  logic [PW-1:0]   pairsLeft;
  logic [PW-1:0]   stepPairs;
  logic            sweepThenStim;
  logic            clearThenLoad;
  logic [WW-1:0]   word;
  logic            pol;
  logic            modeOvo;
  chainKind_e      kind;
  logic [CH_W-1:0] pos;

  function automatic logic chanOk(input logic [CH_W-1:0] ch);
    return (ch != '0) && (int'(ch) <= NUM_CH);
  endfunction

  function automatic logic [WW-1:0] placeCode(input logic [CH_W-1:0] ch,
                                              input logic [1:0] code);
    logic [CH_W-1:0] idx;
    logic [CH_W:0]   sh;
    idx = ch - CH_W'(1);
    sh  = {idx, 1'b0};
    return {{(WW-2){1'b0}}, code} << sh;
  endfunction

  logic [PW-1:0] sweepLen;
  logic          pairPhase;
  logic          phaseEmpty;
  logic          fire;
  logic          wordDriven;
  logic          stepOnly;
  logic          accept;
  opCode_e       op;

  assign op         = opCode_e'(cmdOp);
  assign accept     = cmdValid && (st == S_IDLE);
  assign sweepLen   = (!modeOvo || kind == K_HIZ) ? PW'(NUM_CH)
                                                  : PW'(NUM_CH + 1) - PW'(pos);
  assign stepOnly   = modeOvo && (pos != '0) && (chA >= pos);
  assign pairPhase  = (st == S_LOAD) || (st == S_SWEEP) || (st == S_STIM) || (st == S_STEP);
  assign phaseEmpty = pairPhase && (pairsLeft == '0);
  assign fire       = (st != S_IDLE) && !waiting && !phaseEmpty;
  assign wordDriven = word[0] ^ word[1];
  assign cmdReady   = (st == S_IDLE);

  always_comb begin
    strb.fireShift = fire && (st != S_LATCH);
    strb.fireStore = fire && (st == S_LATCH);
    strb.clearLow  = (st == S_CLEAR);
    case (st)
      S_LOAD:          strb.serBit = bitHi ? (word[1] ^ (pol & wordDriven))
                                           : (word[0] ^ (pol & wordDriven));
      S_SWEEP, S_STEP: strb.serBit = bitHi ? pol : !pol;
      S_STIM:          strb.serBit = bitHi ? !pol : pol;
      default:         strb.serBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st            <= S_CLEAR;
      waiting       <= 1'b0;
      bitHi         <= 1'b0;
      pairsLeft     <= '0;
      stepPairs     <= '0;
      sweepThenStim <= 1'b0;
      clearThenLoad <= 1'b0;
      word          <= '0;
      pol           <= 1'b1;
      modeOvo       <= 1'b0;
      kind          <= K_HIZ;
      pos           <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          waiting <= 1'b0;
          bitHi   <= 1'b0;
          if (accept) begin
            case (op)
              OP_HIZ: begin
                pol           <= cmdPol;
                clearThenLoad <= 1'b0;
                pos           <= '0;
                kind          <= K_HIZ;
                st            <= S_CLEAR;
              end
              OP_GROUND: begin
                if (kind != K_GROUND) begin
                  pol           <= cmdPol;
                  pairsLeft     <= sweepLen;
                  sweepThenStim <= 1'b0;
                  pos           <= '0;
                  kind          <= K_GROUND;
                  st            <= S_SWEEP;
                end
              end
              OP_TWIN, OP_TRIO: begin
                if (chanOk(chA) && chanOk(chB) && (op == OP_TWIN || chanOk(chC))) begin
                  pol           <= cmdPol;
                  word          <= placeCode(chA, 2'b10) + placeCode(chB, 2'b01) +
                                   ((op == OP_TRIO) ? placeCode(chC, 2'b01) : '0);
                  clearThenLoad <= 1'b1;
                  modeOvo       <= 1'b0;
                  kind          <= K_OTHER;
                  pos           <= chA;
                  st            <= S_CLEAR;
                end
              end
              OP_ONEVS: begin
                if (chanOk(chA)) begin
                  pol     <= cmdPol;
                  modeOvo <= 1'b1;
                  kind    <= K_OTHER;
                  pos     <= chA;
                  if (stepOnly) begin
                    pairsLeft <= PW'(chA) - PW'(pos);
                    st        <= S_STEP;
                  end else begin
                    pairsLeft     <= sweepLen;
                    stepPairs     <= PW'(chA) - PW'(1);
                    sweepThenStim <= 1'b1;
                    st            <= S_SWEEP;
                  end
                end
              end
              default: ;
            endcase
          end
        end
        S_CLEAR: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else if (pulseDone) begin
            waiting <= 1'b0;
            if (clearThenLoad) begin
              pairsLeft <= PW'(NUM_CH);
              st        <= S_LOAD;
            end else begin
              st <= S_LATCH;
            end
          end
        end
        S_LATCH: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else if (pulseDone) begin
            waiting <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: begin
          if (waiting) begin
            if (pulseDone) begin
              waiting <= 1'b0;
              bitHi   <= !bitHi;
              if (bitHi) begin
                pairsLeft <= pairsLeft - 1'b1;
                if (st == S_LOAD) word <= word >> 2;
              end
            end
          end else if (phaseEmpty) begin
            bitHi <= 1'b0;
            case (st)
              S_SWEEP: begin
                if (sweepThenStim) begin
                  pairsLeft <= PW'(1);
                  st        <= S_STIM;
                end else begin
                  st <= S_LATCH;
                end
              end
              S_STIM: begin
                pairsLeft <= stepPairs;
                st        <= S_STEP;
              end
              default: st <= S_LATCH;
            endcase
          end else begin
            waiting <= 1'b1;
          end
        end
      endcase
    end
  end

  // R10: the recorded stimulus position never leaves 0..N
  a_r10_pos_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(pos) <= NUM_CH);

  // R11: a twin command with a bad stimulus channel leaves the block idle
  a_r11_bad_chan_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_TWIN && !chanOk(chA)) |=> cmdReady);

  // R11: an unused opcode leaves the block idle
  a_r11_bad_op_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp > 3'd4) |=> cmdReady);

  // R7: a repeated all-ground starts nothing
  a_r7_ground_repeat_skipped: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_GROUND && kind == K_GROUND) |=> (cmdReady && !strb.fireShift));

endmodule

// File: rtl/relay_seq.sv
module relay_seq
  import relay_seq_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int PULSE_W = 2,
  parameter int CH_W    = $clog2(NUM_CH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic [2:0]      cmdOp,
  input  logic [CH_W-1:0] cmdChanA,
  input  logic [CH_W-1:0] cmdChanB,
  input  logic [CH_W-1:0] cmdChanC,
  input  logic            cmdPol,
  output logic            serData,
  output logic            shiftClk,
  output logic            storeClk,
  output logic            clearN
);

  strobe_t strb;
  logic    pulseDone;

  relay_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdReady  (cmdReady),
    .cmdOp     (cmdOp),
    .chA       (cmdChanA),
    .chB       (cmdChanB),
    .chC       (cmdChanC),
    .cmdPol    (cmdPol),
    .pulseDone (pulseDone),
    .strb      (strb)
  );

  relay_seq_dp #(.PULSE_W(PULSE_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pulseDone (pulseDone),
    .serData   (serData),
    .shiftClk  (shiftClk),
    .storeClk  (storeClk),
    .clearN    (clearN)
  );

  // R12: no handshake while a pulse is on the pins
  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk || storeClk) |-> !cmdReady);

  // R5: the storage pulse never coincides with a clear
  a_r5_latch_clear_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeClk) |-> clearN);

endmodule

// File: tb/test_relay_seq.sv
module test_relay_seq;

  localparam int N  = 16;
  localparam int W  = 2;
  localparam int CW = $clog2(N + 1);
  localparam int WW = 2 * N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [2:0]    cmdOp = 3'd0;
  logic [CW-1:0] cmdChanA = '0, cmdChanB = '0, cmdChanC = '0;
  logic          cmdPol = 1'b0;
  logic          serData, shiftClk, storeClk, clearN;

  always #10 clk = ~clk;   // 50 MHz

  relay_seq #(.NUM_CH(N), .PULSE_W(W)) i_relay_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdChanA(cmdChanA), .cmdChanB(cmdChanB), .cmdChanC(cmdChanC),
    .cmdPol(cmdPol), .serData(serData), .shiftClk(shiftClk),
    .storeClk(storeClk), .clearN(clearN)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // ---------------- pin-level chain model ----------------
  logic [WW-1:0] pinChain = '0, image = '0;
  int shiftSeen = 0, storeSeen = 0;

  always @(posedge shiftClk) begin
    if (!clearN) pinChain <= '0;
    else         pinChain <= {serData, pinChain[WW-1:1]};
    shiftSeen++;
  end

  always @(posedge storeClk) begin
    image <= pinChain;
    storeSeen++;
  end

  // ---------------- pulse shape monitor ----------------
  int shHigh = 0, stHigh = 0, lowRun = 1000, widthErr = 0, setupErr = 0, overlapErr = 0;
  logic prevShift = 1'b0, prevStore = 1'b0, prevSer = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (shiftClk && storeClk) overlapErr++;
      if (shiftClk && !prevShift) begin
        if (serData != prevSer) setupErr++;
        if (lowRun < W) widthErr++;
        lowRun = 0;
      end
      if (shiftClk && prevShift && serData != prevSer) setupErr++;
      if (!shiftClk) lowRun++;
      if (shiftClk) shHigh++;
      else begin
        if (prevShift && shHigh != W) widthErr++;
        shHigh = 0;
      end
      if (storeClk) stHigh++;
      else begin
        if (prevStore && stHigh != W) widthErr++;
        stHigh = 0;
      end
    end
    prevShift = shiftClk;
    prevStore = storeClk;
    prevSer   = serData;
  end

  // ---------------- reporting ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "R12", "watchdog expired", 0, 1);
    finishRun();
  end

  // ---------------- expected model ----------------
  logic [WW-1:0] expChain = '0;
  int  expShifts = 0, expStores = 0;
  bit  mOvo = 0;
  int  mKind = 0;          // 0 HiZ, 1 ground, 2 other
  int  mPos = 0;
  bit  mPol = 1;

  function automatic bit chOk(input int x);
    return x >= 1 && x <= N;
  endfunction

  task automatic pushBit(input bit b);
    expChain = {b, expChain[WW-1:1]};
    expShifts++;
  endtask

  task automatic pushSweep(input int n, input bit p);
    for (int i = 0; i < n; i++) begin
      pushBit(!p);
      pushBit(p);
    end
  endtask

  function automatic int sweepPairs();
    return (!mOvo || mKind == 0) ? N : N + 1 - mPos;
  endfunction

  function automatic logic [WW-1:0] codeAt(input int ch, input logic [1:0] v);
    logic [WW-1:0] w;
    w = '0;
    w[2*(ch-1)]   = v[0];
    w[2*(ch-1)+1] = v[1];
    return w;
  endfunction

  task automatic model(input int op, input int a, input int b, input int c, input bit p);
    logic [WW-1:0] word;
    bit b0, b1;
    case (op)
      0: begin
        expChain = '0; expShifts++; expStores++;
        mPos = 0; mKind = 0; mPol = p;
      end
      1: if (mKind != 1) begin
        mPol = p;
        pushSweep(sweepPairs(), p);
        expStores++;
        mKind = 1; mPos = 0;
      end
      2, 3: if (chOk(a) && chOk(b) && (op == 2 || chOk(c))) begin
        word = codeAt(a, 2'b10) + codeAt(b, 2'b01);
        if (op == 3) word = word + codeAt(c, 2'b01);
        mPol = p;
        expChain = '0; expShifts++;
        for (int i = 0; i < N; i++) begin
          b0 = word[2*i]; b1 = word[2*i+1];
          if (b0 ^ b1) begin b0 ^= p; b1 ^= p; end
          pushBit(b0);
          pushBit(b1);
        end
        expStores++;
        mOvo = 0; mKind = 2; mPos = a;
      end
      4: if (chOk(a)) begin
        mPol = p;
        if (mOvo && mPos != 0 && a >= mPos) pushSweep(a - mPos, p);
        else begin
          pushSweep(sweepPairs(), p);
          pushBit(p);
          pushBit(!p);
          pushSweep(a - 1, p);
        end
        expStores++;
        mOvo = 1; mKind = 2; mPos = a;
      end
      default: ;
    endcase
  endtask

  // ---------------- stimulus ----------------
  task automatic send(input int op, input int a, input int b, input int c, input bit p);
    cmdValid = 1'b1;
    cmdOp    = 3'(op);
    cmdChanA = CW'(a); cmdChanB = CW'(b); cmdChanC = CW'(c);
    cmdPol   = p;
    model(op, a, b, c, p);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(image == expChain, req, "chain image", image, expChain);
    check(shiftSeen == expShifts, "R8", "shift pulse total", shiftSeen, expShifts);
    check(storeSeen == expStores, "R5", "store pulse total", storeSeen, expStores);
  endtask

  task automatic doCmd(input string req, input int op, input int a, input int b,
                       input int c, input bit p);
    send(op, a, b, c, p);
    waitIdle();
    compare(req);
  endtask

  function automatic string reqFor(input int op);
    case (op)
      0: return "R6";
      1: return "R7";
      2, 3: return "R9";
      4: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20231));
    repeat (4) @(negedge clk);
    // R1: reset values
    check(clearN == 1'b1, "R1", "clearN in reset", clearN, 1);
    check(shiftClk == 1'b0 && storeClk == 1'b0, "R1", "clocks in reset",
          {shiftClk, storeClk}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b0, "R1", "busy after reset", cmdReady, 0);
    // reset-time all-HiZ
    expShifts = 1; expStores = 1; expChain = '0;
    mOvo = 0; mKind = 0; mPos = 0; mPol = 1;
    // R12: command held while the reset-time sequence is running
    send(1, 0, 0, 0, 1'b1);
    waitIdle();
    compare("R12");
    // R7 repeat ground skip
    doCmd("R7", 1, 0, 0, 0, 1'b0);
    // R3 / R9 twin, polarity 0
    doCmd("R3", 2, 3, 5, 0, 1'b0);
    // R4 / R9 trio, polarity 1
    doCmd("R4", 3, 1, 16, 8, 1'b1);
    // R9 trio with overlapping channels (11 pair and carry)
    doCmd("R9", 3, 7, 7, 7, 1'b1);
    // R10 full path from twin mode
    doCmd("R10", 4, 4, 0, 0, 1'b1);
    // R10 incremental
    doCmd("R10", 4, 9, 0, 0, 1'b1);
    doCmd("R10", 4, 9, 0, 0, 1'b0);
    doCmd("R10", 4, N, 0, 0, 1'b0);
    // R8 lower channel: shortened sweep
    doCmd("R8", 4, 2, 0, 0, 1'b1);
    // R8 ground in this mode, then sweep of N+1
    doCmd("R8", 1, 0, 0, 0, 1'b1);
    doCmd("R8", 4, 3, 0, 0, 1'b1);
    // R6 all-HiZ, then ground with full sweep
    doCmd("R6", 0, 0, 0, 0, 1'b1);
    doCmd("R8", 1, 0, 0, 0, 1'b0);
    // R11 ignored commands
    doCmd("R11", 2, 0, 3, 0, 1'b0);
    doCmd("R11", 3, 2, 3, N + 1, 1'b0);
    doCmd("R11", 4, N + 1, 0, 0, 1'b0);
    doCmd("R11", 6, 1, 1, 1, 1'b1);
    doCmd("R10", 4, 1, 0, 0, 1'b0);
    // R12 back to back
    send(2, 2, 9, 0, 1'b0);
    doCmd("R12", 4, 5, 0, 0, 1'b1);
    // random mix
    for (int it = 0; it < 90; it++) begin
      int r, op, a, b, c;
      bit p;
      r  = $urandom_range(0, 11);
      op = (r < 1) ? 0 : (r < 3) ? 1 : (r < 4) ? 2 : (r < 5) ? 3 :
           (r < 10) ? 4 : $urandom_range(5, 7);
      a  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 31) : $urandom_range(1, N);
      b  = $urandom_range(1, N);
      c  = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, N);
      p  = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 5) == 0) send(op, a, b, c, p);
      else doCmd(reqFor(op), op, a, b, c, p);
    end
    waitIdle();
    compare("R12");
    // R2 pulse shape totals
    check(widthErr == 0, "R2", "pulse width errors", widthErr, 0);
    check(setupErr == 0, "R2", "data setup/hold errors", setupErr, 0);
    check(overlapErr == 0, "R2", "clock overlap", overlapErr, 0);
    finishRun();
  end

endmodule